// File: doc/BRIEF.md
# CPU Bus Address Decoder with Wait-State Acknowledge

This block watches a 16-bit-wide, byte-addressed CPU bus with a 24-bit address space and turns each bus cycle into active-low chip selects and byte-lane strobes for a fixed set of memory regions. The bus carries an address strobe, two data strobes (upper for the even byte lane, lower for the odd byte lane) and a read/write line (1 = read). The regions are a main program ROM, an expansion port, a system ROM, two odd-byte input ports and two odd-byte output ports.

The block also produces the active-low transfer acknowledge. The acknowledge comes after a base cycle, plus extra wait cycles for reads of slow regions. The program ROM has a one-cycle slow-read enable. The expansion port has a 2-bit wait code. A vector-swap input remaps the lowest 1 KiB of the address space onto the system ROM by forcing address bits 23:22. The remapped pair is also driven out so that memories outside the block can use it. The bus inputs are taken as synchronous to `clk`.

Top module: `cpu_bus_decoder`

## Requirements
- R1: A read in 0x000000–0x0FFFFF pulls `prom_rd_n` low, `prom_rd_hi_n` low when the upper strobe is low and `prom_rd_lo_n` low when the lower strobe is low. A write there pulls none of them low.
- R2: Any access in 0x200000–0x2FFFFF with a data strobe low pulls `xp_sel_n` low. For reads, `xp_rd_hi_n`/`xp_rd_lo_n` follow the upper/lower strobes. For writes, `xp_wr_hi_n`/`xp_wr_lo_n` follow them.
- R3: A read in 0xC00000–0xCFFFFF pulls `srom_rd_n` low, and pulls `srom_rd_hi_n`/`srom_rd_lo_n` low with the upper/lower strobes.
- R4: A read with the lower strobe low pulls `in0_rd_n` low in 0x300000–0x31FFFF and `in1_rd_n` low in 0x320000–0x33FFFF. An upper-only read there pulls neither low.
- R5: A write with the lower strobe low pulls `out0_wr_n` low in 0x380000–0x39FFFF and `out1_wr_n` low in 0x3A0000–0x3BFFFF. An upper-only write there pulls neither low.
- R6: While `as_n` is high, every strobe and `ack_n` is high.
- R7: `ack_n` goes low after the first rising clock edge of a cycle to a mapped region. Writes, and reads of the system ROM and of the I/O ports, take this base cycle only.
- R8: While `prom_slow_i` is 1, program ROM reads acknowledge exactly one edge later than the base. Writes to that region are not delayed.
- R9: The 2-bit expansion read wait code adds 0, 1, 2 or 3 edges before acknowledge on expansion port reads. `ack_n` then stays low until `as_n` rises.
- R10: While `vec_swap_i` is 1, addresses 0x000000–0x0003FF are seen with bits 23:22 = 2'b11, so they hit the system ROM. `addr_hi_o` shows the pair actually used. In every other case `addr_hi_o` equals address bits 23:22.
- R11: Accesses to unmapped addresses (for example 0x100000, 0x340000, 0x400000) pull no strobe low and never acknowledge.
- R12: During and right after reset, `ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | 23 | Word address, byte address bits 23:1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper (even) byte data strobe, active low |
| lds_n | input | 1 | Lower (odd) byte data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| prom_slow_i | input | 1 | Adds one wait to program ROM reads |
| xp_wait_i | input | 2 | Expansion port read wait count |
| vec_swap_i | input | 1 | Serve vector window from system ROM |
| addr_hi_o | output | 2 | Remapped address bits 23:22 |
| prom_rd_n | output | 1 | Program ROM read |
| prom_rd_hi_n | output | 1 | Program ROM even-byte read |
| prom_rd_lo_n | output | 1 | Program ROM odd-byte read |
| xp_sel_n | output | 1 | Expansion port any access |
| xp_rd_hi_n | output | 1 | Expansion even-byte read |
| xp_rd_lo_n | output | 1 | Expansion odd-byte read |
| xp_wr_hi_n | output | 1 | Expansion even-byte write |
| xp_wr_lo_n | output | 1 | Expansion odd-byte write |
| srom_rd_n | output | 1 | System ROM read |
| srom_rd_hi_n | output | 1 | System ROM even-byte read |
| srom_rd_lo_n | output | 1 | System ROM odd-byte read |
| in0_rd_n | output | 1 | First input port odd-byte read |
| in1_rd_n | output | 1 | Second input port odd-byte read |
| out0_wr_n | output | 1 | First output port odd-byte write |
| out1_wr_n | output | 1 | Second output port odd-byte write |
| ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 2-bit expansion wait field and a 1 KiB vector window. With these values every wait code from 0 to 3, together with the program ROM slow bit, gives acknowledge latencies of one to four edges. All of these latencies are measured edge by edge. The small vector window puts both sides of its boundary (0x0003FE and 0x000400) within a few directed cycles. Those cycles show the remap taking effect and then stopping, and show the system ROM strobes replacing the program ROM strobes.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [2:0] {
    RG_NONE, RG_PROM, RG_XPORT, RG_SROM, RG_IN0, RG_IN1, RG_OUT0, RG_OUT1
  } region_e;

  typedef struct packed {
    logic prom_rd;
    logic prom_hi;
    logic prom_lo;
    logic xp_sel;
    logic xp_rd_hi;
    logic xp_rd_lo;
    logic xp_wr_hi;
    logic xp_wr_lo;
    logic srom_rd;
    logic srom_hi;
    logic srom_lo;
    logic in0;
    logic in1;
    logic out0;
    logic out1;
  } strobes_t;

  // Region of a 64 KiB page (address bits 23:16).
  function automatic region_e page_region(input logic [7:0] pg);
    region_e r;
    r = RG_NONE;
    if (pg[7:4] == 4'h0)                  r = RG_PROM;
    else if (pg[7:4] == 4'h2)             r = RG_XPORT;
    else if (pg[7:4] == 4'hC)             r = RG_SROM;
    else if (pg[7:4] == 4'h3) begin
      case (pg[3:1])
        3'b000:  r = RG_IN0;
        3'b001:  r = RG_IN1;
        3'b100:  r = RG_OUT0;
        3'b101:  r = RG_OUT1;
        default: r = RG_NONE;
      endcase
    end
    return r;
  endfunction

  // Edges from the start of a cycle until acknowledge; 0 = never.
  function automatic int unsigned ack_edges(input region_e r, input logic rd,
                                            input logic prom_slow,
                                            input int unsigned xwait);
    int unsigned n;
    if (r == RG_NONE) return 0;
    n = 1;
    if (rd && r == RG_PROM && prom_slow) n = n + 1;
    if (rd && r == RG_XPORT)             n = n + xwait;
    return n;
  endfunction

endpackage

// File: rtl/cbd_remap.sv
module cbd_remap #(
  parameter int ADDR_W = 24,
  parameter int VEC_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              swap_i,
  output logic [1:0]        hi_o,
  output logic              in_window_o
);
  localparam int HI_W = ADDR_W - VEC_BITS;

  logic unused_low;
  assign unused_low  = ^addr_i[VEC_BITS-1:1];
  assign in_window_o = (addr_i[ADDR_W-1:VEC_BITS] == '0);
  assign hi_o = (swap_i && in_window_o) ? 2'b11 : addr_i[ADDR_W-1:ADDR_W-2];

  // R10: without the swap the high pair passes through unchanged
  assert_remap_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |-> hi_o == addr_i[ADDR_W-1:ADDR_W-2]);
  // R10: outside the window the swap changes nothing
  assert_remap_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[ADDR_W-1:ADDR_W-2] != 2'b00) |-> hi_o == addr_i[ADDR_W-1:ADDR_W-2]);

  logic unused_hw;
  assign unused_hw = (HI_W > 0);
endmodule

// File: rtl/cbd_region_decode.sv
module cbd_region_decode
  import cbd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [7:0] page_i,
  input  logic     as_n,
  input  logic     uds_n,
  input  logic     lds_n,
  input  logic     rw_i,
  output region_e  region_o,
  output logic     live_o,
  output strobes_t stb_n_o
);
  logic ub, lb, any, rd, wr;
  strobes_t on;

  assign region_o = page_region(page_i);
  assign ub  = !as_n && !uds_n;
  assign lb  = !as_n && !lds_n;
  assign any = ub || lb;
  assign rd  = rw_i;
  assign wr  = !rw_i;
  assign live_o = any && (region_o != RG_NONE);

  always_comb begin
    on = '0;
    unique case (region_o)
      RG_PROM: begin
        on.prom_rd = rd && any;
        on.prom_hi = rd && ub;
        on.prom_lo = rd && lb;
      end
      RG_XPORT: begin
        on.xp_sel   = any;
        on.xp_rd_hi = rd && ub;
        on.xp_rd_lo = rd && lb;
        on.xp_wr_hi = wr && ub;
        on.xp_wr_lo = wr && lb;
      end
      RG_SROM: begin
        on.srom_rd = rd && any;
        on.srom_hi = rd && ub;
        on.srom_lo = rd && lb;
      end
      RG_IN0:  on.in0  = rd && lb;
      RG_IN1:  on.in1  = rd && lb;
      RG_OUT0: on.out0 = wr && lb;
      RG_OUT1: on.out1 = wr && lb;
      default: on = '0;
    endcase
  end

  assign stb_n_o = ~on;

  // R6: no strobe while the address strobe is high
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> &stb_n_o);
  // R11: at most one region select at a time
  assert_one_region_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!stb_n_o.prom_rd, !stb_n_o.xp_sel, !stb_n_o.srom_rd,
              !stb_n_o.in0, !stb_n_o.in1, !stb_n_o.out0, !stb_n_o.out1}));
  // R4: input strobes only on odd-lane reads
  assert_in_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n_o.in0 || !stb_n_o.in1) |-> (!lds_n && rw_i));
  // R5: output strobes only on odd-lane writes
  assert_out_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n_o.out0 || !stb_n_o.out1) |-> (!lds_n && !rw_i));
endmodule

// File: rtl/cbd_ack_timer.sv
module cbd_ack_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_n,
  input  logic             live_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             ack_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!live_i)       cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign reached = (need_i != '0) && (cnt_q >= need_i);
  assign ack_n   = !(live_i && reached);

  // R7: acknowledge never appears without a cycle already running on the last edge
  assert_ack_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!as_n));
  // R9: once given, acknowledge holds while the same cycle continues
  assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && live_i && $stable(need_i)) |=> (ack_n == !live_i) || as_n);
  // R6: acknowledge released while the address strobe is high
  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> ack_n);
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
  import cbd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int XWAIT_W  = 2,
  parameter int VEC_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rw_i,
  input  logic              prom_slow_i,
  input  logic [XWAIT_W-1:0] xp_wait_i,
  input  logic              vec_swap_i,
  output logic [1:0]        addr_hi_o,
  output logic              prom_rd_n,
  output logic              prom_rd_hi_n,
  output logic              prom_rd_lo_n,
  output logic              xp_sel_n,
  output logic              xp_rd_hi_n,
  output logic              xp_rd_lo_n,
  output logic              xp_wr_hi_n,
  output logic              xp_wr_lo_n,
  output logic              srom_rd_n,
  output logic              srom_rd_hi_n,
  output logic              srom_rd_lo_n,
  output logic              in0_rd_n,
  output logic              in1_rd_n,
  output logic              out0_wr_n,
  output logic              out1_wr_n,
  output logic              ack_n
);
  localparam int MAX_NEED = 2 ** XWAIT_W + 1;
  localparam int CNT_W    = $clog2(MAX_NEED + 1);

  logic [1:0]       hi_eff;
  logic             in_window;
  logic [7:0]       page;
  region_e          region;
  logic             live;
  strobes_t         stb_n;
  logic [CNT_W-1:0] need;

  cbd_remap #(.ADDR_W(ADDR_W), .VEC_BITS(VEC_BITS)) remap_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .swap_i(vec_swap_i),
    .hi_o(hi_eff), .in_window_o(in_window)
  );

  assign page = {hi_eff, addr_i[ADDR_W-3:ADDR_W-8]};

  cbd_region_decode decode_i (
    .clk(clk), .rst_n(rst_n), .page_i(page), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rw_i(rw_i), .region_o(region), .live_o(live),
    .stb_n_o(stb_n)
  );

  assign need = CNT_W'(ack_edges(region, rw_i, prom_slow_i, int'(xp_wait_i)));

  cbd_ack_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .live_i(live), .need_i(need),
    .ack_n(ack_n)
  );

  assign addr_hi_o    = hi_eff;
  assign prom_rd_n    = stb_n.prom_rd;
  assign prom_rd_hi_n = stb_n.prom_hi;
  assign prom_rd_lo_n = stb_n.prom_lo;
  assign xp_sel_n     = stb_n.xp_sel;
  assign xp_rd_hi_n   = stb_n.xp_rd_hi;
  assign xp_rd_lo_n   = stb_n.xp_rd_lo;
  assign xp_wr_hi_n   = stb_n.xp_wr_hi;
  assign xp_wr_lo_n   = stb_n.xp_wr_lo;
  assign srom_rd_n    = stb_n.srom_rd;
  assign srom_rd_hi_n = stb_n.srom_hi;
  assign srom_rd_lo_n = stb_n.srom_lo;
  assign in0_rd_n     = stb_n.in0;
  assign in1_rd_n     = stb_n.in1;
  assign out0_wr_n    = stb_n.out0;
  assign out1_wr_n    = stb_n.out1;

  // R10: a swapped vector fetch never selects the program ROM
  assert_swap_no_prom_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_swap_i && in_window) |-> prom_rd_n);
  // R11: unmapped cycles are never acknowledged
  assert_unmapped_noack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NONE) |-> ack_n);
endmodule

// File: tb/cpu_bus_decoder_tb_top.sv
module cpu_bus_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:1] addr = '0;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
  logic prom_slow = 1'b0;
  logic [1:0] xp_wait = 2'd0;
  logic vec_swap = 1'b0;
  logic [1:0] addr_hi;
  logic prom_rd_n, prom_rd_hi_n, prom_rd_lo_n, xp_sel_n, xp_rd_hi_n, xp_rd_lo_n;
  logic xp_wr_hi_n, xp_wr_lo_n, srom_rd_n, srom_rd_hi_n, srom_rd_lo_n;
  logic in0_rd_n, in1_rd_n, out0_wr_n, out1_wr_n, ack_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rw_i(rw), .prom_slow_i(prom_slow), .xp_wait_i(xp_wait),
    .vec_swap_i(vec_swap), .addr_hi_o(addr_hi), .prom_rd_n(prom_rd_n),
    .prom_rd_hi_n(prom_rd_hi_n), .prom_rd_lo_n(prom_rd_lo_n), .xp_sel_n(xp_sel_n),
    .xp_rd_hi_n(xp_rd_hi_n), .xp_rd_lo_n(xp_rd_lo_n), .xp_wr_hi_n(xp_wr_hi_n),
    .xp_wr_lo_n(xp_wr_lo_n), .srom_rd_n(srom_rd_n), .srom_rd_hi_n(srom_rd_hi_n),
    .srom_rd_lo_n(srom_rd_lo_n), .in0_rd_n(in0_rd_n), .in1_rd_n(in1_rd_n),
    .out0_wr_n(out0_wr_n), .out1_wr_n(out1_wr_n), .ack_n(ack_n)
  );

  function automatic logic [14:0] observed();
    return {prom_rd_n, prom_rd_hi_n, prom_rd_lo_n, xp_sel_n, xp_rd_hi_n,
            xp_rd_lo_n, xp_wr_hi_n, xp_wr_lo_n, srom_rd_n, srom_rd_hi_n,
            srom_rd_lo_n, in0_rd_n, in1_rd_n, out0_wr_n, out1_wr_n};
  endfunction

  function automatic logic [23:0] eff_addr(input logic [23:0] a);
    if (vec_swap && a < 24'h000400) return a | 24'hC00000;
    return a;
  endfunction

  // Expected active-low strobes, same bit order as observed().
  function automatic logic [14:0] want_strobes(input logic [23:0] a, input logic r,
                                               input logic ub, input logic lb);
    logic [23:0] e;
    logic p, x, s, i0, i1, o0, o1, any;
    e = eff_addr(a);
    any = ub | lb;
    p  = e <= 24'h0FFFFF;
    x  = e >= 24'h200000 && e <= 24'h2FFFFF;
    s  = e >= 24'hC00000 && e <= 24'hCFFFFF;
    i0 = e >= 24'h300000 && e <= 24'h31FFFF;
    i1 = e >= 24'h320000 && e <= 24'h33FFFF;
    o0 = e >= 24'h380000 && e <= 24'h39FFFF;
    o1 = e >= 24'h3A0000 && e <= 24'h3BFFFF;
    return ~{p & r & any, p & r & ub, p & r & lb,
             x & any, x & r & ub, x & r & lb, x & !r & ub, x & !r & lb,
             s & r & any, s & r & ub, s & r & lb,
             i0 & r & lb, i1 & r & lb, o0 & !r & lb, o1 & !r & lb};
  endfunction

  function automatic int want_edges(input logic [23:0] a, input logic r);
    logic [23:0] e;
    int n;
    e = eff_addr(a);
    if (!(e <= 24'h0FFFFF || (e >= 24'h200000 && e <= 24'h3BFFFF &&
          !(e >= 24'h340000 && e <= 24'h37FFFF)) ||
          (e >= 24'hC00000 && e <= 24'hCFFFFF))) return 0;
    n = 1;
    if (r && e <= 24'h0FFFFF && prom_slow) n++;
    if (r && e >= 24'h200000 && e <= 24'h2FFFFF) n += int'(xp_wait);
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // One bus cycle: drive, check strobes, measure ack latency, release.
  task automatic bus_cycle(input string req, input logic [23:0] a, input logic r,
                           input logic ub, input logic lb);
    int got_edges;
    int exp_edges;
    @(negedge clk);
    addr = a[23:1]; rw = r; uds_n = !ub; lds_n = !lb; as_n = 1'b0;
    #2;
    check({req, " strobes"}, 32'(observed()), 32'(want_strobes(a, r, ub, lb)));
    check({req, " hi bits"}, 32'(addr_hi), 32'(eff_addr(a) >> 22));
    check({req, " no early ack"}, 32'(ack_n), 32'd1);
    exp_edges = want_edges(a, r);
    got_edges = 0;
    for (int n = 1; n <= 6; n++) begin
      @(posedge clk); #2;
      if (!ack_n) begin got_edges = n; break; end
    end
    check({req, " ack edges"}, 32'(got_edges), 32'(exp_edges));
    if (got_edges != 0) begin
      @(posedge clk); #2;
      check({req, " ack held R9"}, 32'(ack_n), 32'd0);
    end
    @(negedge clk);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    #2;
    check({req, " release R6"}, 32'({observed(), ack_n}), 32'hFFFF);
  endtask

  task automatic t_reset();
    #2;
    check("R12 ack in reset", 32'(ack_n), 32'd1);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    check("R12 ack after reset", 32'(ack_n), 32'd1);
    check("R6 idle strobes", 32'(observed()), 32'h7FFF);
  endtask

  task automatic t_prom();
    bus_cycle("R1 prom word read", 24'h000800, 1'b1, 1'b1, 1'b1);
    bus_cycle("R1 prom even read", 24'h0FFFFE, 1'b1, 1'b1, 1'b0);
    bus_cycle("R1 prom odd read", 24'h012340, 1'b1, 1'b0, 1'b1);
    bus_cycle("R1 prom write no strobe", 24'h012340, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_xport();
    bus_cycle("R2 xport word read", 24'h200000, 1'b1, 1'b1, 1'b1);
    bus_cycle("R2 xport odd write", 24'h2FFFFE, 1'b0, 1'b0, 1'b1);
    bus_cycle("R2 xport even write", 24'h255550, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_srom();
    bus_cycle("R3 srom word read", 24'hC00000, 1'b1, 1'b1, 1'b1);
    bus_cycle("R3 srom odd read", 24'hCFFFFE, 1'b1, 1'b0, 1'b1);
    bus_cycle("R7 srom write base ack", 24'hC10000, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_ports();
    bus_cycle("R4 in0 odd read", 24'h300000, 1'b1, 1'b0, 1'b1);
    bus_cycle("R4 in1 odd read", 24'h33FFFE, 1'b1, 1'b0, 1'b1);
    bus_cycle("R4 in0 even read ignored", 24'h310000, 1'b1, 1'b1, 1'b0);
    bus_cycle("R5 out0 odd write", 24'h380000, 1'b0, 1'b0, 1'b1);
    bus_cycle("R5 out1 odd write", 24'h3BFFFE, 1'b0, 1'b0, 1'b1);
    bus_cycle("R5 out1 even write ignored", 24'h3A0000, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_prom_wait();
    prom_slow = 1'b1;
    bus_cycle("R8 prom slow read", 24'h000400, 1'b1, 1'b1, 1'b1);
    bus_cycle("R8 prom slow write", 24'h000400, 1'b0, 1'b1, 1'b1);
    prom_slow = 1'b0;
  endtask

  task automatic t_xport_wait();
    for (int w = 0; w < 4; w++) begin
      xp_wait = 2'(w);
      bus_cycle("R9 xport wait read", 24'h2ABCD0, 1'b1, 1'b1, 1'b1);
    end
    bus_cycle("R9 xport write no wait", 24'h2ABCD0, 1'b0, 1'b1, 1'b1);
    xp_wait = 2'd0;
  endtask

  task automatic t_swap();
    vec_swap = 1'b1;
    bus_cycle("R10 swapped vector", 24'h000000, 1'b1, 1'b1, 1'b1);
    bus_cycle("R10 swapped window top", 24'h0003FE, 1'b1, 1'b0, 1'b1);
    bus_cycle("R10 past window", 24'h000400, 1'b1, 1'b1, 1'b1);
    bus_cycle("R10 xport under swap", 24'h200010, 1'b1, 1'b1, 1'b0);
    vec_swap = 1'b0;
    bus_cycle("R10 unswapped vector", 24'h000000, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_unmapped();
    bus_cycle("R11 hole 0x100000", 24'h100000, 1'b1, 1'b1, 1'b1);
    bus_cycle("R11 hole 0x340000", 24'h340000, 1'b0, 1'b0, 1'b1);
    bus_cycle("R11 hole 0x400000", 24'h400000, 1'b1, 1'b1, 1'b1);
    bus_cycle("R11 hole 0xD00000", 24'hD00000, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_no_data_strobe();
    @(negedge clk);
    addr = 24'h300000 >> 1; rw = 1'b1; as_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check("R6 no data strobe no ack", 32'({observed(), ack_n}), 32'hFFFF);
    @(negedge clk) as_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_prom();
    t_xport();
    t_srom();
    t_ports();
    t_prom_wait();
    t_xport_wait();
    t_swap();
    t_unmapped();
    t_no_data_strobe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule